// File: doc/BRIEF.md
# Dual-Mode Serial Register Port

This block is a slave serial port that lets a host reach a 128-location byte address space. The low part of the space (00h to 1Fh) holds clock registers and the rest (20h to 7Fh) holds general-purpose RAM. The register contents themselves live outside the block. The port only decodes the serial traffic into a simple synchronous read/write bus and drives the serial data line back. A static mode pin selects between a four-wire SPI link and a 3-wire link. In 3-wire mode the data input and data output are tied together outside the block into one shared line.

Every transfer is framed by a chip-enable pulse. The first byte carries the direction flag in its top bit and the start pointer in the remaining seven bits. Each following byte moves one location, and the pointer advances until chip enable drops. The port also emits a strobe that tells the clock logic to copy the running time into a shadow set. It raises this strobe when chip enable rises and each time a pointer in the clock region wraps. It also emits clear pulses for two alarm flags whenever the pointer lands on an alarm register.

All serial inputs are resynchronized to the system clock. The system clock must run at least eight times faster than the serial clock.

Top module: `serial_regport`

## Requirements
- R1: After reset, sdo_oe, reg_wr, reg_rd, snap and both flag_clr bits are all low.
- R2: The first byte after chip enable rises is the command byte. Bit 7 = 1 selects a write and bit 7 = 0 selects a read. Bits 6:0 are the start pointer.
- R3: In SPI mode (spi_mode = 1), the SCLK level seen when chip enable rises fixes the idle polarity. With idle low, input is captured on the falling edge and output changes on the rising edge. With idle high, input is captured on the rising edge and output changes on the falling edge. Bytes travel MSB first in both directions.
- R4: In 3-wire mode (spi_mode = 0), bytes travel LSB first. Input is captured on the rising SCLK edge. Output is driven on the falling edge onto the shared data line.
- R5: Each completed data byte advances the pointer by one, until chip enable falls.
- R6: A pointer at 1Fh advances to 00h and one snap pulse is issued. A pointer at 7Fh advances to 20h and no snap pulse is issued.
- R7: snap pulses for one clock after each rising edge of chip enable.
- R8: A write reaches the bus (reg_wr for one clock, with reg_addr and reg_wdata) only once all 8 bits of a data byte have arrived. A byte cut short by chip enable falling produces no reg_wr.
- R9: sdo_oe stays low until the first read-data bit is driven. It stays low throughout write transfers and returns low after chip enable falls.
- R10: When the pointer is set or advanced to 07h–0Ah, flag_clr[0] pulses. When it is set or advanced to 0Bh–0Eh, flag_clr[1] pulses.
- R11: Each read location produces a one-clock reg_rd pulse, with reg_addr stable during the pulse, and reg_rdata is taken in that clock. This includes the location prefetched after the final byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_mode | input | 1 | 1 selects SPI, 0 selects 3-wire (static) |
| cs_in | input | 1 | Chip enable from the host, high during a transfer |
| sck_in | input | 1 | Serial clock from the host |
| sdi_in | input | 1 | Serial data in (the shared line in 3-wire mode) |
| sdo_out | output | 1 | Serial data out |
| sdo_oe | output | 1 | Output enable for sdo_out; low means high impedance |
| reg_addr | output | 7 | Register-file address (current pointer) |
| reg_wr | output | 1 | One-clock write strobe |
| reg_wdata | output | 8 | Write data |
| reg_rd | output | 1 | One-clock read strobe |
| reg_rdata | input | 8 | Read data, valid in the reg_rd clock |
| snap | output | 1 | Copy-time-to-shadow strobe |
| flag_clr | output | 2 | Alarm flag clear pulses, bit 0 and bit 1 |

## Verification
The bench builds the port with its default parameters: 8-bit bytes, a 7-bit pointer, the clock region ending at 1Fh, RAM from 20h to 7Fh, and two synchronizer stages. At these sizes both wrap points and both alarm windows are reached with bursts of two to four bytes from a chosen start pointer. The bench runs the serial clock at one sixteenth of the system clock, which leaves the synchronizer and prefetch latency well inside a half bit period. It can therefore exercise both SPI polarities and the LSB-first shared-line mode back to back.

// File: rtl/sreg_pkg.sv
package sreg_pkg;

   typedef enum logic {
      PH_CMD  = 1'b0,
      PH_DATA = 1'b1
   } sreg_phase_t;

   function automatic logic in_window(input logic [6:0] a,
                                      input logic [6:0] lo,
                                      input logic [6:0] hi);
      return (a >= lo) && (a <= hi);
   endfunction

endpackage

// File: rtl/sreg_sync.sv
module sreg_sync #(
   parameter int W      = 3,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] st [STAGES];

   genvar g;
   generate
      for (g = 0; g < STAGES; g++) begin : g_stage
         if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) st[g] <= '0;
               else        st[g] <= d;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) st[g] <= '0;
               else        st[g] <= st[g-1];
            end
         end
      end
   endgenerate

   assign q = st[STAGES-1];
endmodule

// File: rtl/sreg_edges.sv
module sreg_edges (
   input  logic clk,
   input  logic rst_n,
   input  logic spi_mode,
   input  logic cs_s,
   input  logic sck_s,
   output logic cs_rise,
   output logic samp_ev,
   output logic drv_ev
);
   logic cs_q, sck_q, idle_hi;
   logic active, sck_up, sck_dn, spi_hi;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cs_q    <= 1'b0;
         sck_q   <= 1'b0;
         idle_hi <= 1'b0;
      end else begin
         cs_q  <= cs_s;
         sck_q <= sck_s;
         if (cs_s && !cs_q) idle_hi <= sck_s;
      end
   end

   assign cs_rise = cs_s & ~cs_q;
   assign active  = cs_s & cs_q;
   assign sck_up  = active & sck_s & ~sck_q;
   assign sck_dn  = active & ~sck_s & sck_q;
   assign spi_hi  = spi_mode & idle_hi;

   // 3-wire and SPI idle-high capture on rise; SPI idle-low captures on fall
   assign samp_ev = (spi_mode && !spi_hi) ? sck_dn : sck_up;
   assign drv_ev  = (spi_mode && !spi_hi) ? sck_up : sck_dn;
endmodule

// File: rtl/sreg_ptr.sv
module sreg_ptr import sreg_pkg::*; #(
   parameter int              ADDR_W   = 7,
   parameter logic [ADDR_W-1:0] RTC_TOP  = 7'h1F,
   parameter logic [ADDR_W-1:0] RAM_BASE = 7'h20,
   parameter logic [ADDR_W-1:0] RAM_TOP  = 7'h7F,
   parameter logic [ADDR_W-1:0] ALM0_LO  = 7'h07,
   parameter logic [ADDR_W-1:0] ALM0_HI  = 7'h0A,
   parameter logic [ADDR_W-1:0] ALM1_LO  = 7'h0B,
   parameter logic [ADDR_W-1:0] ALM1_HI  = 7'h0E
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [ADDR_W-1:0] load_val,
   input  logic              step,
   output logic [ADDR_W-1:0] ptr,
   output logic              rtc_wrap,
   output logic [1:0]        flag_clr
);
   logic [ADDR_W-1:0] nxt;
   logic              moved;

   always_comb begin
      if (ptr <= RTC_TOP)
         nxt = (ptr == RTC_TOP) ? '0 : ptr + 1'b1;
      else
         nxt = (ptr == RAM_TOP) ? RAM_BASE : ptr + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr   <= '0;
         moved <= 1'b0;
      end else begin
         moved <= load | step;
         if (load)      ptr <= load_val;
         else if (step) ptr <= nxt;
      end
   end

   assign rtc_wrap    = step & ~load & (ptr == RTC_TOP);
   assign flag_clr[0] = moved & in_window(7'(ptr), 7'(ALM0_LO), 7'(ALM0_HI));
   assign flag_clr[1] = moved & in_window(7'(ptr), 7'(ALM1_LO), 7'(ALM1_HI));
endmodule

// File: rtl/serial_regport.sv
module serial_regport import sreg_pkg::*; #(
   parameter int                DATA_W      = 8,
   parameter int                ADDR_W      = 7,
   parameter int                SYNC_STAGES = 2,
   parameter logic [ADDR_W-1:0] RTC_TOP     = 7'h1F,
   parameter logic [ADDR_W-1:0] RAM_BASE    = 7'h20,
   parameter logic [ADDR_W-1:0] RAM_TOP     = 7'h7F,
   parameter logic [ADDR_W-1:0] ALM0_LO     = 7'h07,
   parameter logic [ADDR_W-1:0] ALM0_HI     = 7'h0A,
   parameter logic [ADDR_W-1:0] ALM1_LO     = 7'h0B,
   parameter logic [ADDR_W-1:0] ALM1_HI     = 7'h0E
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              spi_mode,
   input  logic              cs_in,
   input  logic              sck_in,
   input  logic              sdi_in,
   output logic              sdo_out,
   output logic              sdo_oe,
   output logic [ADDR_W-1:0] reg_addr,
   output logic              reg_wr,
   output logic [DATA_W-1:0] reg_wdata,
   output logic              reg_rd,
   input  logic [DATA_W-1:0] reg_rdata,
   output logic              snap,
   output logic [1:0]        flag_clr
);
   localparam int CNT_W = $clog2(DATA_W);
   localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

   generate
      if (ADDR_W != DATA_W - 1) begin : g_bad_width
         $error("command byte must hold direction bit plus pointer");
      end
      if (RAM_BASE != RTC_TOP + 1'b1) begin : g_bad_split
         $error("RAM region must start right after clock region");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("at least two synchronizer stages required");
      end
      if (ADDR_W != 7) begin : g_bad_alarm
         $error("alarm window compare is 7 bits wide");
      end
   endgenerate

   logic [2:0] sync_q;
   logic cs_s, sck_s, sdi_s;

   sreg_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({cs_in, sck_in, sdi_in}),
      .q     (sync_q)
   );
   assign {cs_s, sck_s, sdi_s} = sync_q;

   logic cs_rise, samp_ev, drv_ev;

   sreg_edges u_edges (
      .clk      (clk),
      .rst_n    (rst_n),
      .spi_mode (spi_mode),
      .cs_s     (cs_s),
      .sck_s    (sck_s),
      .cs_rise  (cs_rise),
      .samp_ev  (samp_ev),
      .drv_ev   (drv_ev)
   );

   sreg_phase_t       phase;
   logic [CNT_W-1:0]  bit_cnt;
   logic [DATA_W-1:0] sh, byte_in;
   logic              rw_q, wr_q, step_pend, rd_req, rd_q, snap_q;
   logic [DATA_W-1:0] wdata_q, rd_buf;
   logic              byte_end, ptr_load, ptr_step, rtc_wrap;
   logic [ADDR_W-1:0] ptr;

   // bit order is picked by the mode pin: MSB first for SPI, LSB first for 3-wire
   assign byte_in  = spi_mode ? {sh[DATA_W-2:0], sdi_s} : {sdi_s, sh[DATA_W-1:1]};
   assign byte_end = samp_ev & (bit_cnt == LAST_BIT);
   assign ptr_load = byte_end & (phase == PH_CMD);
   assign ptr_step = (byte_end & (phase == PH_DATA) & ~rw_q) | step_pend;

   sreg_ptr #(
      .ADDR_W   (ADDR_W),
      .RTC_TOP  (RTC_TOP),
      .RAM_BASE (RAM_BASE),
      .RAM_TOP  (RAM_TOP),
      .ALM0_LO  (ALM0_LO),
      .ALM0_HI  (ALM0_HI),
      .ALM1_LO  (ALM1_LO),
      .ALM1_HI  (ALM1_HI)
   ) u_ptr (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (ptr_load),
      .load_val (byte_in[ADDR_W-1:0]),
      .step     (ptr_step),
      .ptr      (ptr),
      .rtc_wrap (rtc_wrap),
      .flag_clr (flag_clr)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase     <= PH_CMD;
         bit_cnt   <= '0;
         sh        <= '0;
         rw_q      <= 1'b0;
         wr_q      <= 1'b0;
         wdata_q   <= '0;
         step_pend <= 1'b0;
         rd_req    <= 1'b0;
         rd_q      <= 1'b0;
         rd_buf    <= '0;
         snap_q    <= 1'b0;
      end else begin
         wr_q      <= 1'b0;
         step_pend <= 1'b0;
         rd_req    <= 1'b0;
         rd_q      <= rd_req;
         snap_q    <= cs_rise | rtc_wrap;
         if (rd_q) rd_buf <= reg_rdata;
         if (!cs_s) begin
            phase   <= PH_CMD;
            bit_cnt <= '0;
         end else if (samp_ev) begin
            sh      <= byte_in;
            bit_cnt <= bit_cnt + 1'b1;
            if (byte_end) begin
               if (phase == PH_CMD) begin
                  phase  <= PH_DATA;
                  rw_q   <= byte_in[DATA_W-1];
                  rd_req <= ~byte_in[DATA_W-1];
               end else if (rw_q) begin
                  wr_q      <= 1'b1;
                  wdata_q   <= byte_in;
                  step_pend <= 1'b1;
               end else begin
                  rd_req <= 1'b1;
               end
            end
         end
      end
   end

   logic [CNT_W-1:0]  drv_cnt;
   logic [DATA_W-1:0] tx_sh, tx_src;
   logic              sdo_q, oe_q;

   assign tx_src = (drv_cnt == '0) ? rd_buf : tx_sh;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         drv_cnt <= '0;
         tx_sh   <= '0;
         sdo_q   <= 1'b0;
         oe_q    <= 1'b0;
      end else if (!cs_s) begin
         drv_cnt <= '0;
         oe_q    <= 1'b0;
      end else if (drv_ev && phase == PH_DATA && !rw_q) begin
         oe_q    <= 1'b1;
         drv_cnt <= drv_cnt + 1'b1;
         if (spi_mode) begin
            sdo_q <= tx_src[DATA_W-1];
            tx_sh <= {tx_src[DATA_W-2:0], 1'b0};
         end else begin
            sdo_q <= tx_src[0];
            tx_sh <= {1'b0, tx_src[DATA_W-1:1]};
         end
      end
   end

   assign sdo_out   = sdo_q;
   assign sdo_oe    = oe_q;
   assign reg_addr  = ptr;
   assign reg_wr    = wr_q;
   assign reg_wdata = wdata_q;
   assign reg_rd    = rd_q;
   assign snap      = snap_q;
endmodule

// File: rtl/serial_regport_chk.sv
module serial_regport_chk #(
   parameter int ADDR_W = 7
) (
   input logic              clk,
   input logic              rst_n,
   input logic              sdo_oe,
   input logic              reg_wr,
   input logic              reg_rd,
   input logic [ADDR_W-1:0] reg_addr,
   input logic              snap,
   input logic [1:0]        flag_clr
);
   a_r11_wr_single: assert property (@(posedge clk) disable iff (!rst_n)
      reg_wr |=> !reg_wr);

   a_r11_rd_single: assert property (@(posedge clk) disable iff (!rst_n)
      reg_rd |=> !reg_rd);

   a_r11_addr_steady: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr || reg_rd) |-> $stable(reg_addr));

   a_r2_no_rd_wr: assert property (@(posedge clk) disable iff (!rst_n)
      !(reg_wr && reg_rd));

   a_r9_no_oe_in_write: assert property (@(posedge clk) disable iff (!rst_n)
      sdo_oe |-> !reg_wr);

   a_r10_one_flag: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(flag_clr));

   a_r10_flag_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_clr != 2'b00) |=> (flag_clr == 2'b00));

   a_r7_snap_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      snap |=> !snap);
endmodule

bind serial_regport serial_regport_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .sdo_oe   (sdo_oe),
   .reg_wr   (reg_wr),
   .reg_rd   (reg_rd),
   .reg_addr (reg_addr),
   .snap     (snap),
   .flag_clr (flag_clr)
);

// File: tb/sim_serial_regport.sv
module sim_serial_regport;
   localparam int H = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic spi_mode = 1'b1;
   logic cs_in = 1'b0;
   logic sck_in = 1'b0;
   logic host_bit = 1'b0;
   logic sdi_in, sdo_out, sdo_oe, reg_wr, reg_rd, snap, line3;
   logic [6:0] reg_addr;
   logic [7:0] reg_wdata, reg_rdata;
   logic [1:0] flag_clr;

   always #2 clk = ~clk;

   assign line3  = sdo_oe ? sdo_out : host_bit;
   assign sdi_in = spi_mode ? host_bit : line3;

   serial_regport u0 (
      .clk(clk), .rst_n(rst_n), .spi_mode(spi_mode), .cs_in(cs_in),
      .sck_in(sck_in), .sdi_in(sdi_in), .sdo_out(sdo_out), .sdo_oe(sdo_oe),
      .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
      .reg_rd(reg_rd), .reg_rdata(reg_rdata), .snap(snap), .flag_clr(flag_clr)
   );

   logic [7:0] mem [0:127];
   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < 128; i++) mem[i] <= 8'(i) ^ 8'h5A;
      end else if (reg_wr) begin
         mem[reg_addr] <= reg_wdata;
      end
   end
   assign reg_rdata = mem[reg_addr];

   int snap_cnt = 0, f0_cnt = 0, f1_cnt = 0, wr_cnt = 0, rd_cnt = 0;
   logic oe_seen = 1'b0;
   always @(posedge clk) begin
      if (rst_n) begin
         if (snap)        snap_cnt++;
         if (flag_clr[0]) f0_cnt++;
         if (flag_clr[1]) f1_cnt++;
         if (reg_wr)      wr_cnt++;
         if (reg_rd)      rd_cnt++;
         if (sdo_oe)      oe_seen = 1'b1;
      end
   end

   int checks = 0, errors = 0;
   logic [7:0] txb [0:7];
   logic [7:0] rxb [0:7];

   task automatic chk(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   // nbytes full bytes (command included), then extra partial bits
   task automatic xfer(input logic spi, input logic pol, input int nbytes, input int extra);
      int total;
      spi_mode = spi;
      sck_in   = spi ? pol : 1'b0;
      oe_seen  = 1'b0;
      tick(4);
      cs_in = 1'b1;
      tick(H);
      total = (extra > 0) ? nbytes + 1 : nbytes;
      for (int b = 0; b < total; b++) begin
         int nb;
         nb = (b == nbytes) ? extra : 8;
         rxb[b] = 8'h00;
         for (int i = 0; i < nb; i++) begin
            int idx;
            idx = spi ? 7 - i : i;
            if (spi) begin
               sck_in = ~pol;
               host_bit = txb[b][idx];
               tick(H);
               rxb[b][idx] = sdo_out;
               sck_in = pol;
               tick(H);
            end else begin
               host_bit = txb[b][idx];
               tick(H);
               rxb[b][idx] = line3;
               sck_in = 1'b1;
               tick(H);
               sck_in = 1'b0;
            end
         end
      end
      tick(H);
      cs_in = 1'b0;
      tick(12);
   endtask

   task automatic t_reset;
      chk("R1", "sdo_oe", int'(sdo_oe), 0);
      chk("R1", "reg_wr", int'(reg_wr), 0);
      chk("R1", "reg_rd", int'(reg_rd), 0);
      chk("R1", "snap", int'(snap), 0);
      chk("R1", "flag_clr", int'(flag_clr), 0);
   endtask

   task automatic t_spi_hi_write;
      int s0;
      s0 = snap_cnt;
      txb[0] = 8'hA5; txb[1] = 8'hA5; txb[2] = 8'h3C;
      xfer(1'b1, 1'b1, 3, 0);
      chk("R3", "mem[25] idle-high write", int'(mem[7'h25]), 'hA5);
      chk("R5", "mem[26] burst", int'(mem[7'h26]), 'h3C);
      chk("R7", "snap count per transfer", snap_cnt - s0, 1);
      chk("R9", "oe during write", int'(oe_seen), 0);
   endtask

   task automatic t_spi_lo_read;
      int r0;
      r0 = rd_cnt;
      txb[0] = 8'h25; txb[1] = 8'h00; txb[2] = 8'h00;
      xfer(1'b1, 1'b0, 3, 0);
      chk("R3", "idle-low read byte0", int'(rxb[1]), 'hA5);
      chk("R2", "idle-low read byte1", int'(rxb[2]), 'h3C);
      chk("R9", "oe seen in read", int'(oe_seen), 1);
      chk("R9", "oe after cs low", int'(sdo_oe), 0);
      chk("R11", "rd pulses", rd_cnt - r0, 3);
   endtask

   task automatic t_3w;
      txb[0] = 8'hB0; txb[1] = 8'h1E; txb[2] = 8'h07;
      xfer(1'b0, 1'b0, 3, 0);
      chk("R4", "3-wire LSB-first write", int'(mem[7'h30]), 'h1E);
      chk("R4", "3-wire burst write", int'(mem[7'h31]), 'h07);
      txb[0] = 8'h30; txb[1] = 8'h00; txb[2] = 8'h00;
      xfer(1'b0, 1'b0, 3, 0);
      chk("R4", "3-wire read byte0", int'(rxb[1]), 'h1E);
      chk("R4", "3-wire read byte1", int'(rxb[2]), 'h07);
      chk("R9", "3-wire oe after cs", int'(sdo_oe), 0);
   endtask

   task automatic t_ram_wrap;
      int s0;
      s0 = snap_cnt;
      txb[0] = 8'hFF; txb[1] = 8'h11; txb[2] = 8'h22; txb[3] = 8'h33;
      xfer(1'b1, 1'b1, 4, 0);
      chk("R6", "mem[7F]", int'(mem[7'h7F]), 'h11);
      chk("R6", "RAM wrap to 20", int'(mem[7'h20]), 'h22);
      chk("R6", "after wrap 21", int'(mem[7'h21]), 'h33);
      chk("R6", "no snap on RAM wrap", snap_cnt - s0, 1);
   endtask

   task automatic t_rtc_wrap;
      int s0;
      s0 = snap_cnt;
      txb[0] = 8'h9F; txb[1] = 8'h44; txb[2] = 8'h55;
      xfer(1'b1, 1'b0, 3, 0);
      chk("R6", "mem[1F]", int'(mem[7'h1F]), 'h44);
      chk("R6", "RTC wrap to 00", int'(mem[7'h00]), 'h55);
      chk("R6", "snap on CE rise plus wrap", snap_cnt - s0, 2);
   endtask

   task automatic t_partial;
      int w0;
      w0 = wr_cnt;
      txb[0] = 8'hC0; txb[1] = 8'h66; txb[2] = 8'hFF;
      xfer(1'b1, 1'b1, 2, 5);
      chk("R8", "full byte committed", int'(mem[7'h40]), 'h66);
      chk("R8", "partial byte dropped", int'(mem[7'h41]), 'h41 ^ 'h5A);
      chk("R8", "write pulse count", wr_cnt - w0, 1);
   endtask

   task automatic t_alarm;
      int a0, a1, r0;
      a0 = f0_cnt; a1 = f1_cnt; r0 = rd_cnt;
      txb[0] = 8'h09; txb[1] = 8'h00; txb[2] = 8'h00; txb[3] = 8'h00;
      xfer(1'b0, 1'b0, 4, 0);
      chk("R10", "flag0 clears at 09,0A", f0_cnt - a0, 2);
      chk("R10", "flag1 clears at 0B,0C", f1_cnt - a1, 2);
      chk("R11", "read 09", int'(rxb[1]), 'h09 ^ 'h5A);
      chk("R5", "read 0B", int'(rxb[3]), 'h0B ^ 'h5A);
      chk("R11", "rd pulses incl prefetch", rd_cnt - r0, 4);
   endtask

   logic done = 1'b0;

   initial begin
      tick(5);
      rst_n = 1'b1;
      tick(2);
      t_reset();
      t_spi_hi_write();
      t_spi_lo_read();
      t_3w();
      t_ram_wrap();
      t_rtc_wrap();
      t_partial();
      t_alarm();
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog R1 actual timeout expected completion");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule